// File: doc/BRIEF.md
# Snoop Address-Retry Output Sequencer

This block drives the shared, active-low address-retry line of a bus snooper. It watches the transfer-start strobe and the address-acknowledge strobe. In the cycle after a transfer start, the snoop logic reports whether the address tenure must be retried and whether a copy-back to memory is needed. If a retry is needed, the line is pulled low on the second cycle after transfer start. It is held low until one cycle after the acknowledge strobe. The line is then released with a precharge pattern: one undriven cycle, a short active drive high, and then undriven again.

Other agents may drive the retry line at the same time, so the block never drives it except during a retry or its precharge step. The pad is therefore represented by a data bit and an output enable. A configuration input turns the precharge drive off, so the line just floats back. When a copy-back is needed, a one-cycle bus request is raised in the snoop window, which is the second cycle after the acknowledge strobe.

Cycle numbering used below: the transfer-start strobe is high in cycle n, and the acknowledge strobe is high in cycle a, where a >= n+1. Both are sampled on the rising edge that ends their cycle. All timings below use the default parameters (one undriven gap cycle, one precharge cycle, undriven data value 1).

Top module: `snoop_retry_seq`

## Requirements
- R1: If the block is idle in cycle n, ts_i is high in cycle n, and retry_req_i is high in cycle n+1, then in cycle n+2 retry_oe_o=1 and retry_dat_o=0 (retry asserted). In cycle n+1 retry_oe_o=0.
- R2: If retry_req_i is low in cycle n+1, the line is never driven for that transfer: retry_oe_o stays 0, and any acknowledge strobe is ignored.
- R3: The retry stays asserted from cycle n+2 through cycle a+1, including when a = n+1. In cycle a+2, retry_oe_o=0.
- R4: When pre_off_i is low in cycle a+2, cycle a+3 drives the line high (retry_oe_o=1, retry_dat_o=1), and in cycle a+4 retry_oe_o=0 again.
- R5: When pre_off_i is high in cycle a+2, the drive-high step is skipped, and retry_oe_o stays 0 from cycle a+2 on.
- R6: If copyback_i is high in cycle n+1 together with a retry request, bus_req_o=1 in cycle a+2 only. Otherwise bus_req_o stays 0.
- R7: A ts_i pulse is ignored while a sequence is active. That is from cycle n+1 through cycle a+3, or through a+2 when precharge is off. A start in the first cycle after that is accepted.
- R8: While rst is high, the block is idle from the next cycle on: retry_oe_o=0 and bus_req_o=0.
- R9: Whenever retry_oe_o=0, retry_dat_o equals 1 (the undriven-level parameter).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ts_i | input | 1 | Transfer-start strobe, active high |
| aack_i | input | 1 | Address-acknowledge strobe, active high, one cycle wide |
| retry_req_i | input | 1 | Snoop logic asks for a retry; valid the cycle after ts_i |
| copyback_i | input | 1 | Snoop logic needs a memory update; valid with retry_req_i |
| pre_off_i | input | 1 | Configuration: 1 disables the drive-high precharge step |
| retry_oe_o | output | 1 | Output enable of the retry pad |
| retry_dat_o | output | 1 | Value driven on the retry pad (0 = retry) |
| bus_req_o | output | 1 | Bus request in the snoop window, active high |

## Verification
Every result of this block is due at a fixed distance from a stimulus. The retry asserts two cycles after the transfer-start cycle. The release and the bus request come two cycles after the acknowledge cycle. The precharge drive comes three cycles after it, and the line floats again four cycles after it. The bench's behavioural model records the absolute cycle numbers of the start, the latch and the acknowledge. At each rising edge it works out the expected pad and request values for the cycle that follows. The outputs are compared at the falling edge of every cycle, so a value one cycle early or late is reported against the requirement that sets that timing.

// File: rtl/snprty_pkg.sv
package snprty_pkg;

   // Sequencer phases of one snooped address tenure
   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,   // waiting for a transfer start
      ST_LATCH = 3'd1,   // snoop verdict is sampled at the end of this cycle
      ST_HOLD  = 3'd2,   // retry driven low
      ST_GAP   = 3'd3,   // released, pad undriven
      ST_PRE   = 3'd4    // precharge: pad driven high
   } snp_st_e;

   // Pad control pair
   typedef struct packed {
      logic oe;
      logic dat;
   } pad_t;

   function automatic int unsigned cnt_width(input int unsigned len);
      return (len > 1) ? $clog2(len) : 1;
   endfunction

endpackage

// File: rtl/snprty_span_timer.sv
module snprty_span_timer #(
   parameter int unsigned LEN = 1
) (
   input  logic clk,
   input  logic rst,
   input  logic run,
   output logic last
);
   localparam int unsigned CW = snprty_pkg::cnt_width(LEN);
   localparam logic [CW-1:0] LAST_VAL = CW'(LEN - 1);

   logic [CW-1:0] cnt_q;

   // Counts the cycles spent in one phase; restarts whenever the phase is left
   always_ff @(posedge clk) begin
      if (rst || !run) begin
         cnt_q <= '0;
      end else if (!last) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign last = run && (cnt_q == LAST_VAL);

endmodule

// File: rtl/snprty_fsm.sv
module snprty_fsm
   import snprty_pkg::*;
(
   input  logic    clk,
   input  logic    rst,
   input  logic    ts_i,
   input  logic    aack_i,
   input  logic    retry_req_i,
   input  logic    copyback_i,
   input  logic    pre_off_i,
   input  logic    pre_avail,
   input  logic    gap_last,
   input  logic    pre_last,
   output snp_st_e st_q,
   output logic    br_o
);
   snp_st_e st_d;
   logic    ack_q, ack_d;   // acknowledge already seen for this tenure
   logic    cb_q, cb_d;     // copy-back owed in the snoop window

   always_comb begin
      st_d  = st_q;
      ack_d = ack_q;
      cb_d  = cb_q;
      unique case (st_q)
         ST_IDLE: begin
            ack_d = 1'b0;
            cb_d  = 1'b0;
            if (ts_i) st_d = ST_LATCH;
         end
         ST_LATCH: begin
            if (retry_req_i) begin
               st_d  = ST_HOLD;
               ack_d = aack_i;
               cb_d  = copyback_i;
            end else begin
               st_d = ST_IDLE;
            end
         end
         ST_HOLD: begin
            if (ack_q) st_d = ST_GAP;
            else if (aack_i) ack_d = 1'b1;
         end
         ST_GAP: begin
            cb_d = 1'b0;
            if (gap_last) begin
               st_d = (pre_avail && !pre_off_i) ? ST_PRE : ST_IDLE;
            end
         end
         ST_PRE: begin
            if (pre_last) st_d = ST_IDLE;
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q  <= ST_IDLE;
         ack_q <= 1'b0;
         cb_q  <= 1'b0;
      end else begin
         st_q  <= st_d;
         ack_q <= ack_d;
         cb_q  <= cb_d;
      end
   end

   // Bus request only in the first gap cycle, i.e. two cycles after acknowledge
   assign br_o = (st_q == ST_GAP) && cb_q;

endmodule

// File: rtl/snprty_pad_drive.sv
module snprty_pad_drive
   import snprty_pkg::*;
#(
   parameter bit IDLE_DAT = 1'b1
) (
   input  snp_st_e st,
   output pad_t    pad
);
   always_comb begin
      pad.oe  = 1'b0;
      pad.dat = IDLE_DAT;
      unique case (st)
         ST_HOLD: begin
            pad.oe  = 1'b1;
            pad.dat = 1'b0;
         end
         ST_PRE: begin
            pad.oe  = 1'b1;
            pad.dat = 1'b1;
         end
         default: begin
            pad.oe  = 1'b0;
            pad.dat = IDLE_DAT;
         end
      endcase
   end
endmodule

// File: rtl/snoop_retry_seq.sv
module snoop_retry_seq
   import snprty_pkg::*;
#(
   parameter int unsigned GAP_CYCLES = 1,
   parameter int unsigned PRE_CYCLES = 1,
   parameter bit          IDLE_DAT   = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic ts_i,
   input  logic aack_i,
   input  logic retry_req_i,
   input  logic copyback_i,
   input  logic pre_off_i,
   output logic retry_oe_o,
   output logic retry_dat_o,
   output logic bus_req_o
);
   if (GAP_CYCLES < 1) begin : g_bad_gap
      $error("snoop_retry_seq: GAP_CYCLES must be at least 1");
   end
   if (GAP_CYCLES > 64) begin : g_bad_gap_max
      $error("snoop_retry_seq: GAP_CYCLES too large");
   end
   if (PRE_CYCLES > 64) begin : g_bad_pre_max
      $error("snoop_retry_seq: PRE_CYCLES too large");
   end

   snp_st_e st_q;
   logic    gap_last;
   logic    pre_last;
   logic    pre_avail;
   pad_t    pad;

   snprty_span_timer #(.LEN(GAP_CYCLES)) u_gap_tmr (
      .clk  (clk),
      .rst  (rst),
      .run  (st_q == ST_GAP),
      .last (gap_last)
   );

   // Precharge step is built only when it has a nonzero length
   if (PRE_CYCLES > 0) begin : g_pre
      snprty_span_timer #(.LEN(PRE_CYCLES)) u_pre_tmr (
         .clk  (clk),
         .rst  (rst),
         .run  (st_q == ST_PRE),
         .last (pre_last)
      );
      assign pre_avail = 1'b1;
   end else begin : g_no_pre
      assign pre_last  = 1'b1;
      assign pre_avail = 1'b0;
   end

   snprty_fsm u_fsm (
      .clk         (clk),
      .rst         (rst),
      .ts_i        (ts_i),
      .aack_i      (aack_i),
      .retry_req_i (retry_req_i),
      .copyback_i  (copyback_i),
      .pre_off_i   (pre_off_i),
      .pre_avail   (pre_avail),
      .gap_last    (gap_last),
      .pre_last    (pre_last),
      .st_q        (st_q),
      .br_o        (bus_req_o)
   );

   snprty_pad_drive #(.IDLE_DAT(IDLE_DAT)) u_pad (
      .st  (st_q),
      .pad (pad)
   );

   assign retry_oe_o  = pad.oe;
   assign retry_dat_o = pad.dat;

endmodule

// File: rtl/snprty_chk.sv
module snprty_chk
   import snprty_pkg::*;
#(
   parameter bit IDLE_DAT = 1'b1
) (
   input logic    clk,
   input logic    rst,
   input logic    ts_i,
   input logic    aack_i,
   input logic    retry_req_i,
   input logic    pre_off_i,
   input logic    retry_oe_o,
   input logic    retry_dat_o,
   input logic    bus_req_o,
   input snp_st_e st
);
   // R1: verdict high in the latch cycle gives retry low in the next cycle
   assert_retry_start_R1: assert property (@(posedge clk) disable iff (rst)
      (st == ST_LATCH && retry_req_i) |=> (retry_oe_o && !retry_dat_o));

   // R2: no verdict, no drive
   assert_no_drive_R2: assert property (@(posedge clk) disable iff (rst)
      (st == ST_LATCH && !retry_req_i) |=> !retry_oe_o);

   // R3: a fresh acknowledge while retrying keeps the retry one more cycle
   assert_hold_after_ack_R3: assert property (@(posedge clk) disable iff (rst)
      (retry_oe_o && !retry_dat_o && aack_i && !$past(aack_i))
      |=> (retry_oe_o && !retry_dat_o));

   // R4: the drive-high step is never entered straight from the low drive
   assert_pre_after_gap_R4: assert property (@(posedge clk) disable iff (rst)
      (retry_oe_o && retry_dat_o) |-> $past(!retry_oe_o || retry_dat_o));

   // R5: the drive-high step only begins if precharge was enabled
   assert_pre_off_R5: assert property (@(posedge clk) disable iff (rst)
      (retry_oe_o && retry_dat_o && !$past(retry_oe_o)) |-> !$past(pre_off_i));

   // R6: bus request only right after the retry is released
   assert_br_window_R6: assert property (@(posedge clk) disable iff (rst)
      bus_req_o |-> (!retry_oe_o && $past(retry_oe_o && !retry_dat_o)));

   // R7: a start during the low drive does not reopen the latch cycle
   assert_ignore_ts_R7: assert property (@(posedge clk) disable iff (rst)
      (st == ST_HOLD && ts_i) |=> (st != ST_LATCH));

   // R8: reset leaves the pad undriven and no request
   assert_reset_R8: assert property (@(posedge clk)
      rst |=> (!retry_oe_o && !bus_req_o));

   // R9: undriven pad carries the idle level
   assert_idle_dat_R9: assert property (@(posedge clk) disable iff (rst)
      !retry_oe_o |-> (retry_dat_o == IDLE_DAT));

endmodule

bind snoop_retry_seq snprty_chk #(.IDLE_DAT(IDLE_DAT)) u_chk (
   .clk         (clk),
   .rst         (rst),
   .ts_i        (ts_i),
   .aack_i      (aack_i),
   .retry_req_i (retry_req_i),
   .pre_off_i   (pre_off_i),
   .retry_oe_o  (retry_oe_o),
   .retry_dat_o (retry_dat_o),
   .bus_req_o   (bus_req_o),
   .st          (st_q)
);

// File: tb/snoop_retry_seq_tb.sv
module snoop_retry_seq_tb;
   logic clk = 1'b0;
   logic rst = 1'b1;
   logic ts = 1'b0, aack = 1'b0, req = 1'b0, cb = 1'b0, poff = 1'b0;
   logic oe, dat, br;

   always #10 clk = ~clk;   // 50 MHz

   snoop_retry_seq u_dut (
      .clk(clk), .rst(rst), .ts_i(ts), .aack_i(aack), .retry_req_i(req),
      .copyback_i(cb), .pre_off_i(poff),
      .retry_oe_o(oe), .retry_dat_o(dat), .bus_req_o(br)
   );

   int checks = 0, fails = 0, cyc = 0;
   bit started = 0, done = 0;

   // Behavioural reference: absolute cycle numbers of latch and acknowledge
   int phase = 0, lat_c = 0, ack_c = -1;
   bit m_cb = 0;
   bit e_oe = 0, e_dat = 1, e_br = 0;
   string tag = "R8";

   always @(posedge clk) begin
      bit ign, off_end, no_ret;
      int k;
      ign = 0; off_end = 0; no_ret = 0;
      if (rst) begin
         phase = 0; ack_c = -1; m_cb = 0;
      end else begin
         case (phase)
            0: if (ts) begin phase = 1; lat_c = cyc + 1; end
            1: begin
               ign = ts;
               if (req) begin
                  phase = 2; m_cb = cb; ack_c = aack ? cyc : -1;
               end else begin
                  phase = 0; no_ret = 1;
               end
            end
            default: begin
               ign = ts;
               if (ack_c < 0 && aack) ack_c = cyc;
               if (ack_c >= 0 && cyc == ack_c + 2) begin
                  if (poff) begin phase = 0; off_end = 1; end
               end else if (ack_c >= 0 && cyc == ack_c + 3) begin
                  phase = 0;
               end
            end
         endcase
      end
      k = cyc + 1;
      e_oe = 0; e_dat = 1; e_br = 0;
      if (rst) tag = "R8";
      else if (phase == 2) begin
         if (ack_c < 0 || k <= ack_c + 1) begin
            e_oe = 1; e_dat = 0; tag = (k == lat_c + 1) ? "R1" : "R3";
         end else if (k == ack_c + 2) begin
            e_br = m_cb; tag = m_cb ? "R6" : "R3";
         end else begin
            e_oe = 1; tag = "R4";
         end
      end else if (off_end) tag = "R5";
      else if (no_ret) tag = "R2";
      else tag = "R9";
      if (ign) tag = "R7";
      cyc++;
      started = 1;
   end

   always @(negedge clk) begin
      if (started && !done) begin
         checks++;
         if (oe !== e_oe || dat !== e_dat || br !== e_br) begin
            fails++;
            $display("FAIL %s cycle %0d: oe,dat,br actual %b%b%b expected %b%b%b",
                     tag, cyc, oe, dat, br, e_oe, e_dat, e_br);
         end
      end
   end

   task automatic drv(input bit r, input bit t, input bit a, input bit q, input bit c);
      @(posedge clk);
      #4;
      rst = r; ts = t; aack = a; req = q; cb = c;
   endtask

   // One tenure: start, verdict in the next cycle, acknowledge d cycles after start
   task automatic xfer(input int d, input bit q, input bit c, input bit spam);
      drv(0, 1, 0, 0, 0);
      for (int i = 1; i <= d + 5; i++)
         drv(0, spam && (i <= d + 2), i == d, (i == 1) && q, (i == 1) && c);
   endtask

   initial begin
      repeat (3) drv(1, 0, 0, 0, 0);           // R8 reset state
      drv(0, 0, 0, 0, 0);
      poff = 0;
      xfer(1, 1, 1, 0);                         // R1 R3 R4 R6 early acknowledge
      xfer(3, 1, 0, 0);                         // R3 late acknowledge
      xfer(2, 0, 1, 0);                         // R2 no retry
      poff = 1;
      xfer(4, 1, 1, 0);                         // R5 precharge disabled, R6
      poff = 0;
      xfer(2, 1, 0, 1);                         // R7 starts during sequence
      // R7 back-to-back: start accepted in the first free cycle (a+4)
      drv(0, 1, 0, 0, 0);
      drv(0, 0, 1, 1, 0);
      drv(0, 0, 0, 0, 0);
      drv(0, 0, 0, 0, 0);
      drv(0, 1, 0, 0, 0);                       // a+3: ignored
      drv(0, 1, 0, 0, 0);                       // a+4: accepted
      drv(0, 0, 0, 1, 1);
      drv(0, 0, 0, 0, 0);
      drv(0, 0, 1, 0, 0);
      repeat (6) drv(0, 0, 0, 0, 0);
      // R5 back-to-back with precharge off: free at a+3
      poff = 1;
      drv(0, 1, 0, 0, 0);
      drv(0, 0, 1, 1, 0);
      drv(0, 0, 0, 0, 0);
      drv(0, 0, 0, 0, 0);
      drv(0, 1, 0, 0, 0);                       // a+3: accepted
      drv(0, 0, 0, 0, 0);                       // no retry, R2
      repeat (4) drv(0, 0, 0, 0, 0);
      poff = 0;
      // R8 reset in the middle of a retry
      drv(0, 1, 0, 0, 0);
      drv(0, 0, 0, 1, 1);
      drv(0, 0, 0, 0, 0);
      drv(1, 0, 1, 0, 0);
      drv(1, 0, 0, 0, 0);
      repeat (5) drv(0, 0, 0, 0, 0);
      xfer(1, 1, 0, 1);                         // R7 with start held at latch
      repeat (3) drv(0, 0, 0, 0, 0);
      @(posedge clk);
      #12;
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         fails++;
         $display("FAIL all: watchdog actual running expected finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule